// File: doc/BRIEF.md
# Three-Wire Latched Configuration Loader

This block is the receiving end of a three-wire programming port: a serial clock, a serial data line and a load strobe. All three pins are brought into the system clock domain through two-flop synchronizers. Each synchronized rising edge of the serial clock shifts one data bit into a 24-bit staging register, most significant bit first. The port has no chip select.

A synchronized rising edge of the load strobe copies the whole staging register into one of four configuration latches. The two lowest bits of the staged word choose the latch. Each latch drives a parallel output bus. A latch raises a one-cycle update pulse in the cycle its new value appears. Software on a host controller writes a word as three bytes, then raises the strobe.

The staging register is never cleared. If fewer than 24 bits arrive before a strobe, the word committed is what the register holds at that moment. Serial clock edges seen while the strobe is high have no effect.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is low and after it is released, every latch output is all zeros and every update pulse is low until the first commit.
- R2: Each synchronized rising edge of the serial clock shifts the synchronized data bit into bit 0 of the 24-bit staging register. The older bits move one place towards bit 23, so a 24-bit word is sent most significant bit first.
- R3: A synchronized rising edge of the load strobe copies the full 24-bit staging register into latch k, where k is the value of staged bits [1:0] (0 to 3).
- R4: A commit leaves every latch other than the selected one unchanged.
- R5: The written latch raises its update pulse for exactly one system clock cycle, in the cycle its new value first appears. At most one update pulse is high at any time.
- R6: Rising serial clock edges that occur while the synchronized strobe is high do not change the staging register.
- R7: The staging register is not cleared on commit. A strobe after fewer than 24 new bits commits the previous contents, shifted left by the number of new bits, with the new bits in the low positions.
- R8: Between commits, every latch output holds its value, including while serial bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| ser_data | input | 1 | Serial data pin, sampled on serial clock rising edges |
| ser_load | input | 1 | Load strobe pin; its rising edge commits the staged word |
| latch_data_o | output | 96 | Latch k occupies bits [24k+23 : 24k] |
| latch_upd_o | output | 4 | One-cycle update pulse per latch, bit k for latch k |

## Verification
The bench builds the block with its default parameters: a 24-bit word, a 2-bit latch select (four latches) and two synchronizer stages. This configuration exercises every latch address, full-length words whose high bits reach bit 23, and short words that keep older bits in the staging register. Each serial level is held for four system clocks, so every pin edge passes the synchronizers. The bench can therefore also send strobe-high clock bursts, and check that they are dropped, without depending on where the sampling clock falls.

// File: rtl/cfg_loader_pkg.sv
// Package: shared types for the three-wire configuration loader.
// Assumes: the three serial pins are grouped in one fixed order everywhere.
package cfg_loader_pkg;

    // The three port pins carried together through the synchronizer.
    typedef struct packed {
        logic sclk;
        logic sdat;
        logic load;
    } ser_pins_t;

    localparam int PIN_COUNT = $bits(ser_pins_t);

endpackage

// File: rtl/cfg_sync.sv
// Module: cfg_sync
// A multi-stage synchronizer, one chain per bit, for asynchronous pins.
// Assumes: each input holds its level for longer than STAGES system clocks,
// so the bits do not need to be sampled as one coherent vector.
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the asynchronous pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Later stages: pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_shifter.sv
// Module: cfg_shifter
// Detects edges on the synchronized serial clock and strobe. Shifts data
// MSB first into the staging register, and flags a commit on a strobe rise.
// Assumes: inputs are already synchronous. The register is never cleared.
module cfg_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              load_s,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);

    logic sclk_prev_q;
    logic load_prev_q;
    logic shift_en;

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            load_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
            load_prev_q <= load_s;
        end
    end

    // A clock rise counts only while the strobe is low.
    assign shift_en = sclk_s && !sclk_prev_q && !load_s;
    assign commit_o = load_s && !load_prev_q;

    // Staging register: the new bit enters at bit 0, the oldest leaves at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_o <= '0;
        else if (shift_en) word_o <= {word_o[WORD_W-2:0], sdat_s};
    end

endmodule

// File: rtl/cfg_latch_bank.sv
// Module: cfg_latch_bank
// Holds the configuration latches. The low SEL_W bits of the committed word
// pick which latch to write, and the written latch pulses for one cycle.
// Assumes: commit_i is high for a single cycle per strobe.
module cfg_latch_bank #(
    parameter int WORD_W    = 24,
    parameter int SEL_W     = 2,
    parameter int NUM_LATCH = 1 << SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WORD_W-1:0]           word_i,
    input  logic                        commit_i,
    output logic [NUM_LATCH*WORD_W-1:0] data_o,
    output logic [NUM_LATCH-1:0]        upd_o
);

    logic [SEL_W-1:0] sel;
    assign sel = word_i[SEL_W-1:0];

    for (genvar k = 0; k < NUM_LATCH; k++) begin : g_latch
        logic hit;
        assign hit = commit_i && (sel == SEL_W'(k));

        // Load this latch on a matching commit and pulse its update flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_o[k*WORD_W +: WORD_W] <= '0;
                upd_o[k]                   <= 1'b0;
            end else begin
                upd_o[k] <= hit;
                if (hit) data_o[k*WORD_W +: WORD_W] <= word_i;
            end
        end
    end

endmodule

// File: rtl/serial_cfg_loader.sv
// Module: serial_cfg_loader (top)
// The receive side of a three-wire programming port. It synchronizes the
// pins, assembles 24-bit words, and commits each word to a latch on a
// strobe rise.
// Assumes: the serial clock is slow enough for every pin level to last
// longer than SYNC_STAGES+1 system clocks.
module serial_cfg_loader #(
    parameter int WORD_W      = 24,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_LATCH  = 1 << SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_clk,
    input  logic                        ser_data,
    input  logic                        ser_load,
    output logic [NUM_LATCH*WORD_W-1:0] latch_data_o,
    output logic [NUM_LATCH-1:0]        latch_upd_o
);
    import cfg_loader_pkg::*;

    ser_pins_t            pins_raw;
    ser_pins_t            pins_s;
    logic [WORD_W-1:0]    staged;
    logic                 commit;

    assign pins_raw = '{sclk: ser_clk, sdat: ser_data, load: ser_load};

    cfg_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    cfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s.sclk),
        .sdat_s   (pins_s.sdat),
        .load_s   (pins_s.load),
        .word_o   (staged),
        .commit_o (commit)
    );

    cfg_latch_bank #(.WORD_W(WORD_W), .SEL_W(SEL_W), .NUM_LATCH(NUM_LATCH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_i   (staged),
        .commit_i (commit),
        .data_o   (latch_data_o),
        .upd_o    (latch_upd_o)
    );

endmodule

// File: rtl/cfg_loader_checker.sv
// Module: cfg_loader_checker
// Port-level properties of the loader, attached to every instance by bind.
module cfg_loader_checker #(
    parameter int WORD_W    = 24,
    parameter int NUM_LATCH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_LATCH*WORD_W-1:0] latch_data_o,
    input logic [NUM_LATCH-1:0]        latch_upd_o
);

    // R1: the first cycle out of reset shows cleared latches and no pulses.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_data_o == '0 && latch_upd_o == '0));

    // R5: no two latches pulse at once.
    p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_upd_o));

    // R5: a pulse lasts one cycle.
    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_upd_o != '0) |=> (latch_upd_o == '0));

    for (genvar k = 0; k < NUM_LATCH; k++) begin : g_hold
        // R8 and R4: a latch changes only in the cycle of its own pulse.
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(latch_data_o[k*WORD_W +: WORD_W]) |-> latch_upd_o[k]);
    end

endmodule

bind serial_cfg_loader cfg_loader_checker #(.WORD_W(WORD_W), .NUM_LATCH(NUM_LATCH)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch_data_o (latch_data_o),
    .latch_upd_o  (latch_upd_o)
);

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;

    localparam time CLK_PERIOD = 10ns;
    localparam int  W    = 24;
    localparam int  NL   = 4;
    localparam int  HOLD = 4;
    localparam int  NVEC = 6;
    localparam logic [W-1:0] VEC [NVEC] = '{
        24'hA5C3F0, 24'h123457, 24'hFEDCBA, 24'h800001, 24'h7FFFFF, 24'h3C3C3E
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [NL*W-1:0] latch_data_o;
    logic [NL-1:0]   latch_upd_o;

    int errors = 0, checks = 0;
    int pulse_cnt [NL];
    int run_len [NL];
    int max_run [NL];
    logic [W-1:0] m_reg;
    logic [W-1:0] m_latch [NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_loader i_serial_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .latch_data_o(latch_data_o), .latch_upd_o(latch_upd_o)
    );

    // Count update pulses and their widths, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NL; k++) begin
                if (latch_upd_o[k]) begin
                    pulse_cnt[k]++;
                    run_len[k]++;
                    if (run_len[k] > max_run[k]) max_run[k] = run_len[k];
                end else run_len[k] = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [W-1:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            wait_clk(HOLD);
            ser_clk = 1'b1;
            wait_clk(HOLD);
            ser_clk = 1'b0;
            m_reg = {m_reg[W-2:0], w[i]};
        end
    endtask

    task automatic clear_pulses();
        for (int k = 0; k < NL; k++) begin
            pulse_cnt[k] = 0; run_len[k] = 0; max_run[k] = 0;
        end
    endtask

    // Raise and drop the strobe, then compare every latch and pulse count with the model.
    task automatic strobe_and_check(input string req);
        int sel;
        clear_pulses();
        sel = int'(m_reg[1:0]);
        ser_load = 1'b1;
        wait_clk(HOLD + 4);
        ser_load = 1'b0;
        wait_clk(HOLD + 4);
        m_latch[sel] = m_reg;
        for (int k = 0; k < NL; k++) begin
            chk({req, " R3/R4 latch data"}, latch_data_o[k*W +: W], m_latch[k]);
            chk({req, " R5 pulse count"}, W'(pulse_cnt[k]), (k == sel) ? W'(1) : W'(0));
        end
        chk({req, " R5 pulse width"}, W'(max_run[sel]), W'(1));
    endtask

    task automatic check_all_latches(input string req);
        for (int k = 0; k < NL; k++)
            chk(req, latch_data_o[k*W +: W], m_latch[k]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_reg = '0;
        for (int k = 0; k < NL; k++) m_latch[k] = '0;
        clear_pulses();
        wait_clk(5);
        // R1: state under reset.
        check_all_latches("R1 in reset");
        chk("R1 pulses in reset", W'(latch_upd_o), '0);
        rst_n = 1'b1;
        wait_clk(3);
        check_all_latches("R1 after release");
        chk("R1 no pulse after release", W'(latch_upd_o), '0);

        // R2/R3: table of full-length words, each routed by bits [1:0].
        for (int v = 0; v < NVEC; v++) begin
            send_bits(VEC[v], W);
            chk("R2 staged word equals sent word", m_reg, VEC[v]);
            strobe_and_check("R2 vector");
        end

        // R8: bits shifting without a strobe leave all latches alone.
        clear_pulses();
        send_bits(24'h00000B, 5);
        check_all_latches("R8 hold while shifting");
        chk("R8 no pulse while shifting", W'(pulse_cnt[0] + pulse_cnt[1] + pulse_cnt[2] + pulse_cnt[3]), '0);

        // R7: short word, previous bits kept in the upper positions.
        send_bits(24'h0000C6, 8);
        strobe_and_check("R7 short word");

        // R7: strobe with no new bits commits the register unchanged.
        strobe_and_check("R7 empty word");

        // R6: clock edges while the strobe is high are dropped.
        ser_load = 1'b1;
        wait_clk(HOLD + 4);
        for (int i = 0; i < 5; i++) begin
            ser_data = ~ser_data;
            wait_clk(HOLD);
            ser_clk = 1'b1;
            wait_clk(HOLD);
            ser_clk = 1'b0;
        end
        wait_clk(HOLD);
        ser_load = 1'b0;
        wait_clk(HOLD + 4);
        m_latch[int'(m_reg[1:0])] = m_reg;
        strobe_and_check("R6 strobe-high clocks ignored");

        // R1: a new reset clears every latch.
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        for (int k = 0; k < NL; k++) m_latch[k] = '0;
        m_reg = '0;
        check_all_latches("R1 second reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule